// File: doc/BRIEF.md
# Real-Time Clock Divider Timer with Interrupts

This block is an 8-bit free-running divider counter for a low-power microcontroller. It advances once per 256 Hz enable strobe. That strobe is a single-cycle pulse in the system clock domain, derived from a 32.768 kHz oscillator divided by 128. Bit 0 of the counter toggles at 128 Hz and each higher bit runs at half the rate of the one below, so bit 7 runs at 1 Hz.

Software drives the block through a small register port. It can start and stop counting, clear the counter, read the count, and inspect the four interrupt sources. The sources fire on the 32 Hz, 8 Hz, 2 Hz and 1 Hz falling edges, and each can be enabled or masked. Start and stop requests are applied only on a strobe boundary, and a stop allows one last increment. The run status therefore reads back as running until counting has really ceased. All four sources share one registered interrupt request line.

Register map (2-bit address, 8-bit data; read data is registered and valid one cycle after `rd_en`):

- Address 0, control. Write bit 0 is the run request and write bit 1 is the counter clear. On read, bit 0 is the run status and the other bits are 0.
- Address 1, count. Read only.
- Address 2, pending flags. Bits [3:0] are the 32 Hz, 8 Hz, 2 Hz and 1 Hz causes. Writing 1 to a bit clears it.
- Address 3, enables. Bits [3:0] use the same order as the flags.

Top module: `rtc_tick_timer`

## Requirements
- R1: After synchronous reset the count is 0, the run status reads 0, all flags are 0, all enables are 0 and `irq` is 0.
- R2: The count changes only on a `tick` cycle while counting is active (or by a clear), and then by exactly +1 modulo 256. Between strobes the count holds.
- R3: A write of 1 to control bit 0 takes effect at the next `tick`. That strobe does not increment, and the strobe after it does.
- R4: A write of 0 to control bit 0 lets the next `tick` still increment once, after which the count halts and is retained. A later start resumes from the retained value.
- R5: The run status (control read bit 0) reads 1 from a write of 1 until the strobe that ends counting after a write of 0.
- R6: A control write with bit 1 set clears the count to 0 at once. If bit 0 is set in the same write, counting continues from 0.
- R7: A 1-to-0 change of count bit 2, 4, 6 or 7 during an increment sets flag bit 0, 1, 2 or 3 respectively, whether or not that source is enabled.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it alone. If a clear and a new falling edge of the same source fall in one cycle, the flag stays set.
- R9: `irq` is registered and equals the OR over all sources of (flag AND enable). It updates on the same clock edge as the flags and enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Single-cycle 256 Hz count strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Shared interrupt request |

## Verification
The collision that matters here is a strobe whose increment produces a falling edge, landing in the same cycle as a software write that clears that very flag. The bench provokes it by running the count up to 7 and then raising `tick` together with a flag-clear write of bit 0. It judges the result by reading the flags afterwards and expecting bit 0 still set alongside a count of 8. A second, milder overlap is also covered: a stop request must still allow the increment of the next strobe. This is judged from the count read before and after that strobe.

// File: rtl/rtc_timer_pkg.sv
package rtc_timer_pkg;
  localparam int CNT_W   = 8;
  localparam int NUM_SRC = 4;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 8;
  localparam int POS_W   = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_FLAG  = 2'd2,
    REG_MASK  = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;

  // counter bit watched by each interrupt source, source 0 in the low byte
  localparam logic [NUM_SRC*POS_W-1:0] DEF_SRC_POS = {8'd7, 8'd6, 8'd4, 8'd2};
endpackage

// File: rtl/rtc_run_ctrl.sv
module rtc_run_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_wr_i,
  input  logic             run_val_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             step_o,
  output logic             run_stat_o
);
  logic             run_req_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             step;

  // an increment happens only on a strobe while counting is live
  assign step = tick_i & active_q & ~clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (step) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_req_q <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
    end else begin
      if (run_wr_i) run_req_q <= run_val_i;
      if (tick_i)   active_q  <= run_req_q;
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;
  assign step_o     = step;
  assign run_stat_o = run_req_q | active_q;

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !clr_i) |=> $stable(cnt_q)) else $error("count moved without strobe"); // R2

  AST_CNT_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (tick_i && active_q && !clr_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))) else $error("bad step"); // R2

  AST_ACTIVE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(active_q)) else $error("run state changed off strobe"); // R3

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0)) else $error("clear missed"); // R6
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
  parameter int                       CNT_W   = 8,
  parameter int                       NUM_SRC = 4,
  parameter int                       POS_W   = 8,
  parameter logic [NUM_SRC*POS_W-1:0] SRC_POS = {8'd7, 8'd6, 8'd4, 8'd2}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step_i,
  input  logic [CNT_W-1:0]   cnt_q_i,
  input  logic [CNT_W-1:0]   cnt_d_i,
  input  logic               flag_wr_i,
  input  logic [NUM_SRC-1:0] flag_clr_i,
  input  logic               mask_wr_i,
  input  logic [NUM_SRC-1:0] mask_val_i,
  output logic [NUM_SRC-1:0] flags_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] fall;
  logic [NUM_SRC-1:0] flags_q, flags_d;
  logic [NUM_SRC-1:0] en_q, en_d;
  logic               irq_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int P = int'(SRC_POS[i*POS_W +: POS_W]);
    assign fall[i] = step_i & cnt_q_i[P] & ~cnt_d_i[P];
  end

  always_comb begin
    flags_d = flags_q;
    if (flag_wr_i) flags_d = flags_d & ~flag_clr_i;
    flags_d = flags_d | fall;
    en_d = mask_wr_i ? mask_val_i : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      en_q    <= en_d;
      irq_q   <= |(flags_d & en_d);
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = irq_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    !flag_wr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q))) else $error("flag lost"); // R8

  AST_FLAG_NEEDS_STEP: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> ((flags_q & ~$past(flags_q)) == '0)) else $error("flag set without increment"); // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |-> !irq_o) else $error("irq with all sources masked"); // R9

  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((flags_q & en_q) != '0)) else $error("irq without enabled flag"); // R9
endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port #(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  input  logic               run_stat_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic               run_wr_o,
  output logic               run_val_o,
  output logic               clr_o,
  output logic               flag_wr_o,
  output logic               mask_wr_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  import rtc_timer_pkg::*;

  logic [DATA_W-1:0] rd_q, rd_d;
  logic              ctrl_hit;

  assign ctrl_hit  = wr_en_i && (wr_addr_i == REG_CTRL);
  assign run_wr_o  = ctrl_hit;
  assign run_val_o = wr_data_i[CTRL_RUN_BIT];
  assign clr_o     = ctrl_hit && wr_data_i[CTRL_CLR_BIT];
  assign flag_wr_o = wr_en_i && (wr_addr_i == REG_FLAG);
  assign mask_wr_o = wr_en_i && (wr_addr_i == REG_MASK);

  always_comb begin
    case (rd_addr_i)
      REG_CTRL:  rd_d = DATA_W'(run_stat_i);
      REG_COUNT: rd_d = DATA_W'(cnt_i);
      REG_FLAG:  rd_d = DATA_W'(flags_i);
      default:   rd_d = DATA_W'(en_i);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer #(
  parameter int ADDR_W  = rtc_timer_pkg::ADDR_W,
  parameter int DATA_W  = rtc_timer_pkg::DATA_W,
  parameter int CNT_W   = rtc_timer_pkg::CNT_W,
  parameter int NUM_SRC = rtc_timer_pkg::NUM_SRC,
  parameter int POS_W   = rtc_timer_pkg::POS_W,
  parameter logic [NUM_SRC*POS_W-1:0] SRC_POS = rtc_timer_pkg::DEF_SRC_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic               run_wr, run_val, clr, flag_wr, mask_wr;
  logic [CNT_W-1:0]   cnt, cnt_next;
  logic               step, run_stat;
  logic [NUM_SRC-1:0] flags, en;

  rtc_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .NUM_SRC(NUM_SRC)) u_port (
    .clk(clk), .rst(rst),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .run_stat_i(run_stat), .cnt_i(cnt), .flags_i(flags), .en_i(en),
    .run_wr_o(run_wr), .run_val_o(run_val), .clr_o(clr),
    .flag_wr_o(flag_wr), .mask_wr_o(mask_wr), .rd_data_o(rd_data)
  );

  rtc_run_ctrl #(.CNT_W(CNT_W)) u_run (
    .clk(clk), .rst(rst), .tick_i(tick),
    .run_wr_i(run_wr), .run_val_i(run_val), .clr_i(clr),
    .cnt_o(cnt), .cnt_next_o(cnt_next), .step_o(step), .run_stat_o(run_stat)
  );

  rtc_irq_unit #(.CNT_W(CNT_W), .NUM_SRC(NUM_SRC), .POS_W(POS_W), .SRC_POS(SRC_POS)) u_irq (
    .clk(clk), .rst(rst), .step_i(step),
    .cnt_q_i(cnt), .cnt_d_i(cnt_next),
    .flag_wr_i(flag_wr), .flag_clr_i(wr_data[NUM_SRC-1:0]),
    .mask_wr_i(mask_wr), .mask_val_i(wr_data[NUM_SRC-1:0]),
    .flags_o(flags), .en_o(en), .irq_o(irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq && rd_data == '0)) else $error("reset state wrong"); // R1

  AST_RUN_STAT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en && run_stat) |=> run_stat) else $error("run status dropped off strobe"); // R5
endmodule

// File: tb/test_rtc_tick_timer.sv
module test_rtc_tick_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_cap = 1'b0;
  bit         done = 0;

  always #10 clk = ~clk;

  rtc_tick_timer i_rtc_tick_timer (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // monitor: read data is valid after the edge that saw rd_en
  always @(posedge clk) rd_cap <= rd_en;
  always @(negedge clk) begin
    if (rd_cap && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rd_data !== e) begin
        fails++;
        $display("FAIL %s: got %02h expected %02h", t, rd_data, e);
      end
    end
  end

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq got %0b expected %0b", t, irq, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_reg(2'd0, 8'h00, "R1 run status");
    expect_reg(2'd1, 8'h00, "R1 count");
    expect_reg(2'd2, 8'h00, "R1 flags");
    expect_reg(2'd3, 8'h00, "R1 enables");
    expect_irq(1'b0, "R1 irq");

    // R3 start at next strobe, first strobe does not count
    do_write(2'd0, 8'h01);
    expect_reg(2'd0, 8'h01, "R5 status after start");
    do_tick(1);
    expect_reg(2'd1, 8'h00, "R3 no increment on first strobe");
    do_tick(1);
    expect_reg(2'd1, 8'h01, "R3 increment on second strobe");
    repeat (20) @(negedge clk);
    expect_reg(2'd1, 8'h01, "R2 hold between strobes");

    // R7 32 Hz edge (bit 2: 7 -> 8) with source masked
    do_tick(7);
    expect_reg(2'd1, 8'h08, "R2 count after 7 strobes");
    expect_reg(2'd2, 8'h01, "R7 flag set though masked");
    expect_irq(1'b0, "R9 masked source no irq");
    do_write(2'd3, 8'h01);
    expect_irq(1'b1, "R9 irq after enabling");
    do_write(2'd2, 8'h00);
    expect_reg(2'd2, 8'h01, "R8 write 0 leaves flag");
    do_write(2'd2, 8'h01);
    expect_reg(2'd2, 8'h00, "R8 write 1 clears flag");
    expect_irq(1'b0, "R9 irq drops after clear");

    // R4 stop: one more increment, then hold
    do_write(2'd0, 8'h00);
    expect_reg(2'd0, 8'h01, "R5 status still running");
    do_tick(1);
    expect_reg(2'd1, 8'h09, "R4 extra increment after stop");
    expect_reg(2'd0, 8'h00, "R5 status after real stop");
    do_tick(3);
    expect_reg(2'd1, 8'h09, "R4 count retained while stopped");
    do_write(2'd0, 8'h01);
    do_tick(1);
    expect_reg(2'd1, 8'h09, "R4 restart waits a strobe");
    do_tick(1);
    expect_reg(2'd1, 8'h0A, "R4 resumes from retained value");

    // R6 clear plus run
    do_write(2'd0, 8'h03);
    expect_reg(2'd1, 8'h00, "R6 clear immediate");
    expect_reg(2'd0, 8'h01, "R6 still running");
    do_tick(1);
    expect_reg(2'd1, 8'h01, "R6 counts from zero");

    // R8 collision: strobe edge and clear of same flag in one cycle
    do_tick(6);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    expect_reg(2'd1, 8'h08, "R2 count at collision");
    expect_reg(2'd2, 8'h01, "R8 set wins over clear");
    do_write(2'd2, 8'h0F);
    do_write(2'd3, 8'h00);

    // R7 slower sources, R9 shared line
    do_write(2'd0, 8'h03);
    do_tick(128);
    expect_reg(2'd1, 8'h80, "R2 count at half wrap");
    expect_reg(2'd2, 8'h07, "R7 bits 2,4,6 fell, 7 not");
    do_write(2'd3, 8'h08);
    expect_irq(1'b0, "R9 only 1 Hz enabled, not pending");
    do_tick(128);
    expect_reg(2'd1, 8'h00, "R2 wrap to zero");
    expect_reg(2'd2, 8'h0F, "R7 1 Hz flag set on wrap");
    expect_irq(1'b1, "R9 1 Hz irq");
    do_write(2'd2, 8'h08);
    expect_reg(2'd2, 8'h07, "R8 only bit 3 cleared");
    expect_irq(1'b0, "R9 masked pending flags give no irq");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule